// File: doc/BRIEF.md
# Synchronous DRAM Strobe Sequencer

This block produces the row strobe, the column strobes and the row/column multiplexer select for a 16-bit main memory. The memory is built from 4-bit-wide dynamic RAM devices, so each bank holds four devices and each byte lane holds two of them. All timing comes from a four-stage shift chain clocked by the processor clock, with no asynchronous delay elements. An access completes with no wait states: the column strobe reaches the devices two clocks after the row strobe.

Only the bank-select and beat bits of the address reach the block. The row/column address multiplexer sits outside the block and follows `mux_col_o`. For a burst transfer the block drives the two lowest word-address lines itself. It steps them once per beat, modulo four, from the address the processor presented, and gives each beat its own column strobe. A two-bit strap states how much memory is fitted: one or two banks of either 1 Mbit or 4 Mbit devices, which gives 512 KB, 1 MB, 2 MB or 4 MB.

Top module: `dram_seq`

## Requirements
- R1: While reset is held and after it is released, `ras_no_o` is 1, `cas_no_o` is 4'b1111, `mux_col_o` is 0 and `lo_addr_o` is 0.
- R2: An access is accepted at a rising edge where `req_i` and `stb_i` are both 1 and the timing chain is empty. `ras_no_o` goes low after that edge.
- R3: `mux_col_o` goes to 1 (column) one clock after `ras_no_o` goes low.
- R4: The column strobes go active one clock after `mux_col_o` switches. In a single access they stay active until the request ends.
- R5: Column strobe index is bank*2+lane. Bit 0 is bank 0 low byte, bit 1 is bank 0 high byte, bit 2 is bank 1 low byte and bit 3 is bank 1 high byte. A lane is strobed only when its `be_i` bit (bit 0 low byte, bit 1 high byte) was 1 at acceptance. All strobes are active low.
- R6: `size_i[0]`=1 means a second bank is fitted, and `size_i[1]`=1 means 4 Mbit devices. The bank is taken from byte-address bit 19 with 1 Mbit devices and from bit 21 with 4 Mbit devices. With one bank fitted, bank 0 is always used.
- R7: With `burst_i`=1 the access issues four column strobe pulses. Each pulse is active for one clock, with one inactive clock between pulses. The fourth pulse stays active until the request ends.
- R8: `lo_addr_o` equals `addr_i[2:1]` after acceptance. It advances by one, modulo four, in each inactive gap between burst beats, and it holds after the fourth beat.
- R9: The row strobe stays active for the whole access. When `req_i` is 0 at a rising edge, all strobes and `mux_col_o` are inactive after that edge.
- R10: A request is not accepted while the chain is busy. After an access that reached its column phase, the earliest acceptance is at the second edge after the releasing edge.
- R11: Address, byte enables, burst flag and size strap are sampled at acceptance. Changing them, or pulsing `stb_i`, during an access does not affect the strobes or `lo_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Memory request, held for the whole access |
| stb_i | input | 1 | Start strobe, qualifies the first cycle of a request |
| addr_i | input | 22 | Byte address |
| be_i | input | 2 | Byte lane enables, bit 0 low byte |
| burst_i | input | 1 | Access is a four-beat burst |
| size_i | input | 2 | Fitted-memory strap: bit 0 second bank, bit 1 4 Mbit devices |
| ras_no_o | output | 1 | Row strobe, active low |
| cas_no_o | output | 4 | Column strobes per bank and lane, active low |
| mux_col_o | output | 1 | Address multiplexer select, 1 selects column |
| lo_addr_o | output | 2 | Generated low word-address bits |

## Verification
The bench starts a burst at each of the four low addresses, so a counter that does not wrap, or that starts from 0, shows up as a wrong `lo_addr_o` in a gap. A missing gap shows up as a column strobe that stays active through the gap clocks. Single accesses cover all four strap settings with addresses that set only bit 19 or only bit 21, so a wrong bank bit or an ignored strap drives the wrong strobe group. A request that is re-presented right after release checks that the precharge stage blocks acceptance for one edge. Inputs changed in mid-access, together with a second strobe pulse, check that a design which re-latches would move the strobes or the address.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int unsigned LANES  = 2;
  localparam int unsigned BANKS  = 2;
  localparam int unsigned BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    bank_t      bank;
    lane_mask_t lanes;
    logic       burst;
  } acc_ctx_t;

  function automatic bank_t pick_bank(input logic two_banks, input logic big_dev,
                                      input logic bit_small, input logic bit_large);
    bank_t b;
    b = '0;
    if (two_banks) b[0] = big_dev ? bit_large : bit_small;
    return b;
  endfunction

endpackage

// File: rtl/dram_seq_chain.sv
module dram_seq_chain #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              stb_i,
  output logic              start_o,
  output logic [STAGES-1:0] stage_o
);

  logic [STAGES-1:0] stage_q, stage_d;

  assign start_o = req_i & stb_i & ~(|stage_q);

  assign stage_d[0] = start_o | (stage_q[0] & req_i);

  for (genvar k = 1; k < STAGES; k++) begin : g_tap
    if (k == STAGES - 1) begin : g_guard
      // last stage not gated by request: one-clock precharge guard
      assign stage_d[k] = stage_q[k-1];
    end else begin : g_shift
      assign stage_d[k] = stage_q[k-1] & req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  a_r2_start_sets_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> stage_q[0]);

  a_r9_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (stage_q[STAGES-2:0] == '0));

endmodule

// File: rtl/dram_seq_burst.sv
module dram_seq_burst #(
  parameter int unsigned BEATS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     burst_i,
  input  logic [$clog2(BEATS)-1:0] lo_i,
  input  logic                     cas_win_i,
  output logic [$clog2(BEATS)-1:0] lo_o,
  output logic                     gap_o
);

  localparam int unsigned BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              burst_q, gap_q;
  logic [BEAT_W-1:0] cnt_q, lo_q;
  logic              step;

  assign step = cas_win_i & burst_q & ~gap_q & (cnt_q != LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      gap_q   <= 1'b0;
      cnt_q   <= '0;
      lo_q    <= '0;
    end else if (start_i) begin
      burst_q <= burst_i;
      gap_q   <= 1'b0;
      cnt_q   <= '0;
      lo_q    <= lo_i;
    end else if (!cas_win_i) begin
      gap_q   <= 1'b0;
    end else if (gap_q) begin
      gap_q   <= 1'b0;
    end else if (step) begin
      gap_q   <= 1'b1;
      cnt_q   <= cnt_q + BEAT_W'(1);
      lo_q    <= lo_q + BEAT_W'(1);
    end
  end

  assign lo_o  = lo_q;
  assign gap_o = gap_q;

  a_r8_lo_steps_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> (lo_q == $past(lo_q) || lo_q == $past(lo_q) + BEAT_W'(1)));

  a_r7_gap_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q |=> !gap_q);

endmodule

// File: rtl/dram_seq_casdec.sv
module dram_seq_casdec
  import dram_seq_pkg::*;
(
  input  logic                   en_i,
  input  bank_t                  bank_i,
  input  lane_mask_t             lanes_i,
  output logic [BANKS*LANES-1:0] cas_no_o
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign cas_no_o[b*LANES+l] = ~(en_i & (bank_i == bank_t'(b)) & lanes_i[l]);
    end
  end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned DEV_SMALL_AW = 18,
  parameter int unsigned DEV_LARGE_AW = 20,
  parameter int unsigned CHAIN_STAGES = 4,
  parameter int unsigned BURST_BEATS  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          stb_i,
  input  logic [DEV_LARGE_AW+1:0]       addr_i,
  input  logic [LANES-1:0]              be_i,
  input  logic                          burst_i,
  input  logic [1:0]                    size_i,
  output logic                          ras_no_o,
  output logic [BANKS*LANES-1:0]        cas_no_o,
  output logic                          mux_col_o,
  output logic [$clog2(BURST_BEATS)-1:0] lo_addr_o
);

  localparam int unsigned BEAT_W     = $clog2(BURST_BEATS);
  localparam int unsigned BANK_BIT_S = DEV_SMALL_AW + 1;
  localparam int unsigned BANK_BIT_L = DEV_LARGE_AW + 1;
  localparam int unsigned TAP_RAS    = 0;
  localparam int unsigned TAP_MUX    = 1;
  localparam int unsigned TAP_CAS    = 2;

  logic [CHAIN_STAGES-1:0] stage;
  logic                    start, gap;
  acc_ctx_t                ctx_q, ctx_d;
  logic                    unused_bits;

  dram_seq_chain #(.STAGES(CHAIN_STAGES)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .stb_i   (stb_i),
    .start_o (start),
    .stage_o (stage)
  );

  assign ctx_d.bank  = pick_bank(size_i[0], size_i[1], addr_i[BANK_BIT_S], addr_i[BANK_BIT_L]);
  assign ctx_d.lanes = be_i;
  assign ctx_d.burst = burst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctx_q <= '0;
    else if (start) ctx_q <= ctx_d;
  end

  dram_seq_burst #(.BEATS(BURST_BEATS)) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .burst_i   (burst_i),
    .lo_i      (addr_i[BEAT_W:1]),
    .cas_win_i (stage[TAP_CAS]),
    .lo_o      (lo_addr_o),
    .gap_o     (gap)
  );

  dram_seq_casdec u_casdec (
    .en_i     (stage[TAP_CAS] & ~gap),
    .bank_i   (ctx_q.bank),
    .lanes_i  (ctx_q.lanes),
    .cas_no_o (cas_no_o)
  );

  assign ras_no_o  = ~stage[TAP_RAS];
  assign mux_col_o = stage[TAP_MUX];

  assign unused_bits = ^{addr_i, stage, ctx_q.burst};

  a_r3_mux_after_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mux_col_o) |-> $past(!ras_no_o));

  a_r4_cas_needs_mux: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_no_o != '1) |-> mux_col_o);

  a_r9_cas_inside_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_no_o != '1) |-> !ras_no_o);

  a_r5_one_bank_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((cas_no_o[LANES-1:0] != '1) && (cas_no_o[2*LANES-1:LANES] != '1)));

  a_r10_ras_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no_o) |=> ras_no_o);

endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, stb_i = 1'b0, burst_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic [1:0]  be_i = '0, size_i = '0;
  logic        ras_no_o, mux_col_o;
  logic [3:0]  cas_no_o;
  logic [1:0]  lo_addr_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dram_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .stb_i(stb_i),
    .addr_i(addr_i), .be_i(be_i), .burst_i(burst_i), .size_i(size_i),
    .ras_no_o(ras_no_o), .cas_no_o(cas_no_o), .mux_col_o(mux_col_o),
    .lo_addr_o(lo_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  function automatic logic [3:0] exp_cas(input logic [21:0] a, input logic [1:0] be,
                                         input logic [1:0] sz);
    logic bank;
    bank = sz[0] ? (sz[1] ? a[21] : a[19]) : 1'b0;
    return ~(bank ? {be, 2'b00} : {2'b00, be});
  endfunction

  task automatic release_and_idle(input string tag);
    req_i = 1'b0;
    tick();
    chk({tag, " R9 ras off"}, ras_no_o, 1);
    chk({tag, " R9 cas off"}, cas_no_o, 4'hF);
    chk({tag, " R9 mux row"}, mux_col_o, 0);
    tick();
    tick();
  endtask

  task automatic single_access(input logic [21:0] a, input logic [1:0] be,
                               input logic [1:0] sz, input int hold);
    logic [3:0] exp;
    exp = exp_cas(a, be, sz);
    addr_i = a; be_i = be; size_i = sz; burst_i = 1'b0;
    req_i = 1'b1; stb_i = 1'b1;
    tick();
    stb_i = 1'b0;
    chk("R2 ras active", ras_no_o, 0);
    chk("R3 mux row first", mux_col_o, 0);
    chk("R4 cas idle in row", cas_no_o, 4'hF);
    chk("R8 lo from addr", lo_addr_o, a[2:1]);
    tick();
    chk("R3 mux column", mux_col_o, 1);
    chk("R4 cas idle in mux", cas_no_o, 4'hF);
    tick();
    chk("R5 R6 cas decode", cas_no_o, exp);
    for (int i = 0; i < hold; i++) begin
      tick();
      chk("R4 cas held", cas_no_o, exp);
      chk("R9 ras held", ras_no_o, 0);
    end
    release_and_idle("single");
  endtask

  task automatic burst_access(input logic [1:0] lo);
    logic [21:0] a;
    logic [1:0]  l;
    a = {19'h0, lo, 1'b0};
    addr_i = a; be_i = 2'b11; size_i = 2'b11; burst_i = 1'b1;
    req_i = 1'b1; stb_i = 1'b1;
    tick();
    stb_i = 1'b0;
    chk("R8 burst start lo", lo_addr_o, lo);
    tick();
    chk("R3 burst mux", mux_col_o, 1);
    tick();
    chk("R7 beat0 cas", cas_no_o, 4'hC);
    chk("R8 beat0 lo", lo_addr_o, lo);
    for (int k = 1; k < 4; k++) begin
      l = lo + 2'(k);
      tick();
      chk("R7 gap cas", cas_no_o, 4'hF);
      chk("R8 gap lo", lo_addr_o, l);
      chk("R9 ras in gap", ras_no_o, 0);
      tick();
      chk("R7 beat cas", cas_no_o, 4'hC);
      chk("R8 beat lo", lo_addr_o, l);
    end
    l = lo + 2'd3;
    tick();
    chk("R7 last beat held", cas_no_o, 4'hC);
    chk("R8 lo holds", lo_addr_o, l);
    burst_i = 1'b0;
    release_and_idle("burst");
  endtask

  task automatic restart_gap();
    addr_i = 22'h0; be_i = 2'b01; size_i = 2'b00; burst_i = 1'b0;
    req_i = 1'b1; stb_i = 1'b1;
    tick(); stb_i = 1'b0;
    tick(); tick();
    chk("R10 cas reached", cas_no_o, 4'hE);
    req_i = 1'b0;
    tick();
    chk("R9 released", ras_no_o, 1);
    req_i = 1'b1; stb_i = 1'b1;
    tick();
    chk("R10 blocked one edge", ras_no_o, 1);
    tick();
    chk("R10 accepted next", ras_no_o, 0);
    stb_i = 1'b0;
    release_and_idle("restart");
  endtask

  task automatic sampled_inputs();
    addr_i = 22'h080004; be_i = 2'b10; size_i = 2'b01; burst_i = 1'b0;
    req_i = 1'b1; stb_i = 1'b1;
    tick();
    stb_i = 1'b0;
    addr_i = 22'h000002; be_i = 2'b01; size_i = 2'b00; burst_i = 1'b1;
    tick();
    stb_i = 1'b1;
    tick();
    stb_i = 1'b0;
    chk("R11 cas from sampled", cas_no_o, 4'h7);
    chk("R11 lo from sampled", lo_addr_o, 2'd2);
    tick();
    chk("R11 no burst gap", cas_no_o, 4'h7);
    chk("R11 lo unchanged", lo_addr_o, 2'd2);
    burst_i = 1'b0;
    release_and_idle("sampled");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick();
    chk("R1 ras in reset", ras_no_o, 1);
    chk("R1 cas in reset", cas_no_o, 4'hF);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 ras after reset", ras_no_o, 1);
    chk("R1 cas after reset", cas_no_o, 4'hF);
    chk("R1 mux after reset", mux_col_o, 0);
    chk("R1 lo after reset", lo_addr_o, 0);
    stb_i = 1'b1;
    tick();
    chk("R2 stb without req ignored", ras_no_o, 1);
    stb_i = 1'b0;
    req_i = 1'b1;
    tick();
    chk("R2 req without stb ignored", ras_no_o, 1);
    req_i = 1'b0;
    tick();

    single_access(22'h000000, 2'b01, 2'b00, 2);
    single_access(22'h080002, 2'b10, 2'b00, 1);
    single_access(22'h080006, 2'b11, 2'b01, 1);
    single_access(22'h200000, 2'b01, 2'b11, 0);
    single_access(22'h080000, 2'b10, 2'b11, 0);
    single_access(22'h200004, 2'b11, 2'b10, 1);
    single_access(22'h280000, 2'b11, 2'b01, 0);

    for (int s = 0; s < 4; s++) burst_access(2'(s));

    restart_gap();
    sampled_inputs();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule